// File: doc/BRIEF.md
# Legacy Keyboard Port Emulation Registers

This block sits inside a USB host controller. It lets software written for an old keyboard controller keep using the two byte-wide I/O ports at 60h and 64h. The block holds four 32-bit registers: control, input, output and status. Host firmware can reach all four through a memory-mapped register port. There, reads never change anything, and a write changes only the register it targets, with one exception: a write to the output register also raises OutputFull.

When the emulation-enable bit is set, I/O cycles to the data port (60h) and the command port (64h) are steered onto the same registers. These I/O cycles also run the keyboard-controller handshake:
- Reading the data port takes the pending keyboard byte and clears OutputFull.
- Writing either port leaves a byte in the input register and raises InputFull.
- CmdData records which of the two ports received the last written byte.

Firmware watches these flags through the memory port and answers by loading new bytes into the output register. When emulation is off, every I/O cycle is ignored.

Top module: `kbd_legacy_emu`

## Requirements
- R1: After reset, all four registers read as zero and `emu_en` is low.
- R2: Register offsets are fixed: control is at 100h, input at 104h, output at 108h and status at 10Ch. `mem_rdata` is combinational from `mem_addr`. Any other address reads as zero, and a write to it changes nothing.
- R3: Control bit 0 is the emulation enable. It drives `emu_en` from the cycle after the write. Control bits 31:1 read as zero.
- R4: While `emu_en` is low, I/O reads and writes change no register, and `io_rdata` is zero.
- R5: While enabled, an I/O read of 60h returns the output byte on `io_rdata` in the same cycle. OutputFull (status bit 0) is cleared after the edge.
- R6: While enabled, an I/O write of 60h stores `io_wdata` in input bits 7:0. It sets InputFull (status bit 1) and clears CmdData (status bit 3).
- R7: While enabled, an I/O read of 64h returns status bits 7:0 on `io_rdata` and changes no register.
- R8: While enabled, an I/O write of 64h stores `io_wdata` in input bits 7:0. It sets both InputFull and CmdData.
- R9: Memory reads have no side effects. A memory write to the input register keeps bits 7:0 and leaves the flags alone. A memory write to status loads bits 0, 1 and 3 from the written word. All unused bits of input, output and status read as zero.
- R10: A memory write to the output register keeps bits 7:0 and sets OutputFull.
- R11: When a memory write and an I/O cycle hit the same field in the same cycle, the memory write decides the result. This applies to the input byte, the flags written through status, and OutputFull on an output write.
- R12: I/O cycles to any address other than 60h and 64h are ignored, and `io_rdata` stays zero for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mem_wr | input | 1 | Memory-mapped write strobe |
| mem_addr | input | 12 | Byte offset within the operational register space |
| mem_wdata | input | 32 | Memory write data |
| mem_rdata | output | 32 | Memory read data for `mem_addr` (combinational) |
| io_rd | input | 1 | Legacy I/O read strobe |
| io_wr | input | 1 | Legacy I/O write strobe |
| io_addr | input | 16 | Legacy I/O port address |
| io_wdata | input | 8 | Legacy I/O write byte |
| io_rdata | output | 8 | Legacy I/O read byte (combinational) |
| emu_en | output | 1 | Emulation enable, control bit 0 |

## Verification
On every cycle, the assertions check these behaviours:
- each I/O strobe produces its flag effect on the next edge;
- the status port read and the disabled state leave the flags and the input byte unchanged;
- a memory write wins over an I/O cycle;
- `io_rdata` stays silent while disabled.

Other behaviours can only be shown by the bench scenarios, because they need a history of operations to observe:
- the address map, including unmapped offsets;
- the reset values;
- the masking of the unused bits;
- the handshake as seen over a long mixed sequence of memory and I/O traffic.

// File: rtl/kbd_emu_pkg.sv
package kbd_emu_pkg;
  localparam int REG_W      = 32;
  localparam int BYTE_W     = 8;
  localparam int NUM_REGS   = 4;
  localparam int REG_STRIDE = 4;

  localparam int IDX_CTRL = 0;
  localparam int IDX_IN   = 1;
  localparam int IDX_OUT  = 2;
  localparam int IDX_STAT = 3;

  localparam int CTRL_EN_BIT = 0;
  localparam int ST_OBF_BIT  = 0;
  localparam int ST_IBF_BIT  = 1;
  localparam int ST_CMD_BIT  = 3;

  typedef struct packed {
    logic cmd_last;
    logic in_full;
    logic out_full;
  } kbd_flags_t;

  function automatic logic [REG_W-1:0] flags_to_word(kbd_flags_t f);
    logic [REG_W-1:0] w;
    w              = '0;
    w[ST_OBF_BIT]  = f.out_full;
    w[ST_IBF_BIT]  = f.in_full;
    w[ST_CMD_BIT]  = f.cmd_last;
    return w;
  endfunction
endpackage

// File: rtl/kbd_emu_decode.sv
module kbd_emu_decode
  import kbd_emu_pkg::*;
#(
  parameter int                 MEM_AW       = 12,
  parameter int                 IO_AW        = 16,
  parameter logic [MEM_AW-1:0]  REG_BASE     = 12'h100,
  parameter logic [IO_AW-1:0]   IO_DATA_PORT = 16'h0060,
  parameter logic [IO_AW-1:0]   IO_CMD_PORT  = 16'h0064
) (
  input  logic                emu_en,
  input  logic                mem_wr,
  input  logic [MEM_AW-1:0]   mem_addr,
  input  logic                io_rd,
  input  logic                io_wr,
  input  logic [IO_AW-1:0]    io_addr,
  output logic [NUM_REGS-1:0] mem_sel,
  output logic [NUM_REGS-1:0] mem_we,
  output logic                io_data_rd,
  output logic                io_data_wr,
  output logic                io_cmd_rd,
  output logic                io_cmd_wr
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    localparam logic [MEM_AW-1:0] OFS = REG_BASE + MEM_AW'(g * REG_STRIDE);
    assign mem_sel[g] = (mem_addr == OFS);
    assign mem_we[g]  = mem_wr & mem_sel[g];
  end

  logic data_hit;
  logic cmd_hit;

  always_comb begin
    data_hit   = emu_en & (io_addr == IO_DATA_PORT);
    cmd_hit    = emu_en & (io_addr == IO_CMD_PORT);
    io_data_rd = data_hit & io_rd;
    io_data_wr = data_hit & io_wr;
    io_cmd_rd  = cmd_hit & io_rd;
    io_cmd_wr  = cmd_hit & io_wr;
  end
endmodule

// File: rtl/kbd_emu_flags.sv
module kbd_emu_flags
  import kbd_emu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_data_rd,
  input  logic       io_data_wr,
  input  logic       io_cmd_wr,
  input  logic       out_we,
  input  logic       stat_we,
  input  kbd_flags_t wflags,
  output kbd_flags_t flags
);
  kbd_flags_t flags_q;
  kbd_flags_t flags_d;
  logic       flags_en;

  always_comb begin
    flags_d  = flags_q;
    flags_en = io_data_rd | io_data_wr | io_cmd_wr | out_we | stat_we;
    if (io_data_rd) flags_d.out_full = 1'b0;
    if (io_data_wr) begin
      flags_d.in_full  = 1'b1;
      flags_d.cmd_last = 1'b0;
    end
    if (io_cmd_wr) begin
      flags_d.in_full  = 1'b1;
      flags_d.cmd_last = 1'b1;
    end
    if (out_we)  flags_d.out_full = 1'b1;
    if (stat_we) flags_d = wflags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags = flags_q;

  p_data_rd_clears_obf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_data_rd && !out_we && !stat_we) |=> !flags.out_full);

  p_data_wr_handshake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_data_wr && !stat_we) |=> (flags.in_full && !flags.cmd_last));

  p_cmd_wr_handshake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cmd_wr && !stat_we) |=> (flags.in_full && flags.cmd_last));

  p_out_wr_sets_obf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && !stat_we) |=> flags.out_full);

  p_stat_wr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> (flags == $past(wflags)));

  p_quiet_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_data_rd && !io_data_wr && !io_cmd_wr && !out_we && !stat_we) |=> $stable(flags));
endmodule

// File: rtl/kbd_emu_store.sv
module kbd_emu_store
  import kbd_emu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] mem_we,
  input  logic [BYTE_W-1:0]   mem_wbyte,
  input  logic                io_byte_wr,
  input  logic [BYTE_W-1:0]   io_wdata,
  output logic                ctrl_en,
  output logic [BYTE_W-1:0]   in_byte,
  output logic [BYTE_W-1:0]   out_byte
);
  logic              ctrl_q, ctrl_d, ctrl_ce;
  logic [BYTE_W-1:0] in_q, in_d;
  logic              in_ce;
  logic [BYTE_W-1:0] out_q, out_d;
  logic              out_ce;

  always_comb begin
    ctrl_ce = mem_we[IDX_CTRL];
    ctrl_d  = mem_wbyte[CTRL_EN_BIT];
    in_ce   = mem_we[IDX_IN] | io_byte_wr;
    in_d    = mem_we[IDX_IN] ? mem_wbyte : io_wdata;
    out_ce  = mem_we[IDX_OUT];
    out_d   = mem_wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
      in_q   <= '0;
      out_q  <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (in_ce)   in_q   <= in_d;
      if (out_ce)  out_q  <= out_d;
    end
  end

  assign ctrl_en  = ctrl_q;
  assign in_byte  = in_q;
  assign out_byte = out_q;

  p_in_mem_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we[IDX_IN] |=> (in_byte == $past(mem_wbyte)));

  p_in_io_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_byte_wr && !mem_we[IDX_IN]) |=> (in_byte == $past(io_wdata)));

  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we[IDX_CTRL] |=> (ctrl_en == $past(mem_wbyte[CTRL_EN_BIT])));
endmodule

// File: rtl/kbd_emu_rdmux.sv
module kbd_emu_rdmux
  import kbd_emu_pkg::*;
(
  input  logic [NUM_REGS-1:0]            mem_sel,
  input  logic [NUM_REGS-1:0][REG_W-1:0] words,
  input  logic                           io_data_rd,
  input  logic                           io_cmd_rd,
  output logic [REG_W-1:0]               mem_rdata,
  output logic [BYTE_W-1:0]              io_rdata
);
  always_comb begin
    mem_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      mem_rdata = mem_rdata | ({REG_W{mem_sel[i]}} & words[i]);
    end
    io_rdata = ({BYTE_W{io_data_rd}} & words[IDX_OUT][BYTE_W-1:0])
             | ({BYTE_W{io_cmd_rd}}  & words[IDX_STAT][BYTE_W-1:0]);
  end
endmodule

// File: rtl/kbd_legacy_emu.sv
module kbd_legacy_emu
  import kbd_emu_pkg::*;
#(
  parameter int                MEM_AW       = 12,
  parameter int                IO_AW        = 16,
  parameter logic [MEM_AW-1:0] REG_BASE     = 12'h100,
  parameter logic [IO_AW-1:0]  IO_DATA_PORT = 16'h0060,
  parameter logic [IO_AW-1:0]  IO_CMD_PORT  = 16'h0064
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_wr,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [REG_W-1:0]  mem_wdata,
  output logic [REG_W-1:0]  mem_rdata,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  output logic              emu_en
);
  logic [NUM_REGS-1:0]            mem_sel;
  logic [NUM_REGS-1:0]            mem_we;
  logic                           io_data_rd, io_data_wr, io_cmd_rd, io_cmd_wr;
  logic                           ctrl_en;
  logic [BYTE_W-1:0]              in_byte, out_byte;
  kbd_flags_t                     flags, wflags;
  logic [NUM_REGS-1:0][REG_W-1:0] words;
  logic                           unused_wdata_hi;

  assign unused_wdata_hi = ^mem_wdata[REG_W-1:BYTE_W];

  kbd_emu_decode #(
    .MEM_AW(MEM_AW), .IO_AW(IO_AW), .REG_BASE(REG_BASE),
    .IO_DATA_PORT(IO_DATA_PORT), .IO_CMD_PORT(IO_CMD_PORT)
  ) u_decode (
    .emu_en(ctrl_en), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
    .mem_sel(mem_sel), .mem_we(mem_we),
    .io_data_rd(io_data_rd), .io_data_wr(io_data_wr),
    .io_cmd_rd(io_cmd_rd), .io_cmd_wr(io_cmd_wr)
  );

  always_comb begin
    wflags.out_full = mem_wdata[ST_OBF_BIT];
    wflags.in_full  = mem_wdata[ST_IBF_BIT];
    wflags.cmd_last = mem_wdata[ST_CMD_BIT];
  end

  kbd_emu_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .io_data_rd(io_data_rd), .io_data_wr(io_data_wr), .io_cmd_wr(io_cmd_wr),
    .out_we(mem_we[IDX_OUT]), .stat_we(mem_we[IDX_STAT]),
    .wflags(wflags), .flags(flags)
  );

  kbd_emu_store u_store (
    .clk(clk), .rst_n(rst_n),
    .mem_we(mem_we), .mem_wbyte(mem_wdata[BYTE_W-1:0]),
    .io_byte_wr(io_data_wr | io_cmd_wr), .io_wdata(io_wdata),
    .ctrl_en(ctrl_en), .in_byte(in_byte), .out_byte(out_byte)
  );

  always_comb begin
    words                        = '0;
    words[IDX_CTRL][CTRL_EN_BIT] = ctrl_en;
    words[IDX_IN][BYTE_W-1:0]    = in_byte;
    words[IDX_OUT][BYTE_W-1:0]   = out_byte;
    words[IDX_STAT]              = flags_to_word(flags);
  end

  kbd_emu_rdmux u_rdmux (
    .mem_sel(mem_sel), .words(words),
    .io_data_rd(io_data_rd), .io_cmd_rd(io_cmd_rd),
    .mem_rdata(mem_rdata), .io_rdata(io_rdata)
  );

  assign emu_en = ctrl_en;

  p_off_state_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!emu_en && !mem_wr) |=> ($stable(flags) && $stable(in_byte)));

  p_off_io_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !emu_en |-> (io_rdata == '0));

  p_cmd_rd_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cmd_rd && !mem_wr && !io_wr) |=> ($stable(flags) && $stable(in_byte)));
endmodule

// File: tb/kbd_legacy_emu_bench.sv
`timescale 1ns/1ps
module kbd_legacy_emu_bench;
  logic        clk;
  logic        rst_n;
  logic        mem_wr;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        io_rd, io_wr;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        emu_en;

  int total = 0;
  int bad   = 0;

  logic       m_en;
  logic [7:0] m_in, m_out;
  logic       m_obf, m_ibf, m_cmd;

  kbd_legacy_emu u_kbd_legacy_emu (
    .clk(clk), .rst_n(rst_n),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .emu_en(emu_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] stat_word();
    return {28'd0, m_cmd, 1'b0, m_ibf, m_obf};
  endfunction

  function automatic logic [31:0] exp_mem(input logic [11:0] a);
    case (a)
      12'h100: return {31'd0, m_en};
      12'h104: return {24'd0, m_in};
      12'h108: return {24'd0, m_out};
      12'h10C: return stat_word();
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [7:0] exp_io(input logic rd, input logic [15:0] a);
    if (!m_en || !rd) return 8'd0;
    if (a == 16'h0060) return m_out;
    if (a == 16'h0064) return stat_word()[7:0];
    return 8'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_update(input logic mw, input logic [11:0] ma, input logic [31:0] wd,
                              input logic ir, input logic iw, input logic [15:0] ia,
                              input logic [7:0] iwd);
    logic dr, dw, cw;
    dr = m_en && ir && ia == 16'h0060;
    dw = m_en && iw && ia == 16'h0060;
    cw = m_en && iw && ia == 16'h0064;
    if (dr) m_obf = 1'b0;
    if (dw) begin m_ibf = 1'b1; m_cmd = 1'b0; end
    if (cw) begin m_ibf = 1'b1; m_cmd = 1'b1; end
    if (dw || cw) m_in = iwd;
    if (mw) begin
      case (ma)
        12'h100: m_en = wd[0];
        12'h104: m_in = wd[7:0];
        12'h108: begin m_out = wd[7:0]; m_obf = 1'b1; end
        12'h10C: begin m_obf = wd[0]; m_ibf = wd[1]; m_cmd = wd[3]; end
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic mw, input logic [11:0] ma, input logic [31:0] wd,
                      input logic ir, input logic iw, input logic [15:0] ia,
                      input logic [7:0] iwd, input string tag);
    @(negedge clk);
    mem_wr = mw; mem_addr = ma; mem_wdata = wd;
    io_rd = ir; io_wr = iw; io_addr = ia; io_wdata = iwd;
    #1;
    chk({tag, " mem_rdata"}, mem_rdata, exp_mem(ma));
    chk({tag, " io_rdata"}, {24'd0, io_rdata}, {24'd0, exp_io(ir, ia)});
    chk("R3 emu_en", {31'd0, emu_en}, {31'd0, m_en});
    @(posedge clk);
    model_update(mw, ma, wd, ir, iw, ia, iwd);
  endtask

  task automatic peek(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    mem_wr = 1'b0; io_rd = 1'b0; io_wr = 1'b0; mem_addr = a;
    #1;
    chk(tag, mem_rdata, exp);
  endtask

  initial begin
    #500000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] maddrs [6];
    logic [15:0] iaddrs [4];
    maddrs = '{12'h100, 12'h104, 12'h108, 12'h10C, 12'h110, 12'h0FC};
    iaddrs = '{16'h0060, 16'h0064, 16'h0061, 16'h0065};
    void'($urandom(32'd20240611));
    m_en = 0; m_in = 0; m_out = 0; m_obf = 0; m_ibf = 0; m_cmd = 0;
    mem_wr = 0; mem_addr = 0; mem_wdata = 0; io_rd = 0; io_wr = 0; io_addr = 0; io_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(12'h100, 32'd0, "R1 ctrl");
    peek(12'h104, 32'd0, "R1 input");
    peek(12'h108, 32'd0, "R1 output");
    peek(12'h10C, 32'd0, "R1 status");
    chk("R1 emu_en", {31'd0, emu_en}, 32'd0);

    // R4 disabled: I/O ignored
    step(0, 12'h104, 0, 0, 1, 16'h0060, 8'h55, "R4");
    step(0, 12'h10C, 0, 1, 0, 16'h0060, 8'h00, "R4");
    peek(12'h104, 32'd0, "R4 input");
    peek(12'h10C, 32'd0, "R4 status");

    // R3 enable, upper bits masked
    step(1, 12'h100, 32'hFFFF_FFFF, 0, 0, 16'h0, 8'h0, "R3");
    peek(12'h100, 32'd1, "R3 ctrl");
    chk("R3 emu_en", {31'd0, emu_en}, 32'd1);

    // R10 output write
    step(1, 12'h108, 32'hDEAD_BEA5, 0, 0, 16'h0, 8'h0, "R10");
    peek(12'h108, 32'h0000_00A5, "R10 output");
    peek(12'h10C, 32'h0000_0001, "R10 status");

    // R5 data port read
    step(0, 12'h10C, 0, 1, 0, 16'h0060, 8'h0, "R5");
    peek(12'h10C, 32'd0, "R5 status");

    // R6 data port write
    step(0, 12'h104, 0, 0, 1, 16'h0060, 8'h3C, "R6");
    peek(12'h104, 32'h3C, "R6 input");
    peek(12'h10C, 32'h02, "R6 status");

    // R8 command port write
    step(0, 12'h104, 0, 0, 1, 16'h0064, 8'hD4, "R8");
    peek(12'h104, 32'hD4, "R8 input");
    peek(12'h10C, 32'h0A, "R8 status");

    // R7 status port read
    step(0, 12'h10C, 0, 1, 0, 16'h0064, 8'h0, "R7");
    peek(12'h10C, 32'h0A, "R7 status");
    peek(12'h104, 32'hD4, "R7 input");

    // R9 memory input/status writes
    step(1, 12'h104, 32'h1234_5677, 0, 0, 16'h0, 8'h0, "R9");
    peek(12'h104, 32'h77, "R9 input");
    peek(12'h10C, 32'h0A, "R9 status");
    step(1, 12'h10C, 32'hFFFF_FFFF, 0, 0, 16'h0, 8'h0, "R9");
    peek(12'h10C, 32'h0B, "R9 status mask");

    // R12 other I/O ports
    step(0, 12'h104, 0, 0, 1, 16'h0061, 8'hEE, "R12");
    step(0, 12'h104, 0, 1, 1, 16'h0065, 8'hEE, "R12");
    peek(12'h104, 32'h77, "R12 input");
    peek(12'h10C, 32'h0B, "R12 status");

    // R2 unmapped offsets
    step(1, 12'h110, 32'hFFFF_FFFF, 0, 0, 16'h0, 8'h0, "R2");
    step(1, 12'h0FC, 32'hFFFF_FFFF, 0, 0, 16'h0, 8'h0, "R2");
    peek(12'h110, 32'd0, "R2 unmapped");
    peek(12'h100, 32'd1, "R2 ctrl");
    peek(12'h108, 32'hA5, "R2 output");

    // R11 collisions
    step(1, 12'h10C, 32'h0, 0, 1, 16'h0060, 8'h99, "R11");
    peek(12'h10C, 32'h0, "R11 status");
    peek(12'h104, 32'h99, "R11 input io");
    step(1, 12'h104, 32'h11, 0, 1, 16'h0064, 8'h22, "R11");
    peek(12'h104, 32'h11, "R11 input mem");
    peek(12'h10C, 32'h0A, "R11 status");
    step(1, 12'h108, 32'h5A, 1, 0, 16'h0060, 8'h0, "R11");
    peek(12'h10C, 32'h0B, "R11 obf");

    // R4 disable again
    step(1, 12'h100, 32'h0, 0, 0, 16'h0, 8'h0, "R4");
    step(0, 12'h10C, 0, 1, 0, 16'h0060, 8'h0, "R4");
    peek(12'h10C, 32'h0B, "R4 status held");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic        mw, ir, iw;
      logic [11:0] ma;
      logic [31:0] wd;
      logic [15:0] ia;
      mw = ($urandom % 4) == 0;
      ma = maddrs[$urandom % 6];
      wd = $urandom;
      if (ma == 12'h100) wd[0] = ($urandom % 8) != 0;
      ir = ($urandom % 3) == 0;
      iw = ($urandom % 3) == 0;
      ia = iaddrs[$urandom % 4];
      step(mw, ma, wd, ir, iw, ia, 8'($urandom), ia == 16'h0060 ? "R5" : "R7");
    end

    @(negedge clk);
    mem_wr = 0; io_rd = 0; io_wr = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule